// File: doc/BRIEF.md
# Directory Pipeline Entry Arbiter

This block sits at the head of a directory controller pipeline and decides, for each opportunity, which of three sources enters stage 2. The sources are the head of the local eviction queue, an incoming coherence response and an incoming coherence request. For the eviction queue head and the incoming request, the block sends the tag and set fields of the address to an external transaction tracking table. It then combines the lookup answer, a decode of the tracked transient state, the availability of both outbound networks and the busy flags of stages 2 and 3 into one eligibility flag per source.

A fixed priority picks one eligible source: eviction first, then response, then request. The grant is registered. In the cycle after the decision, the block raises a one-cycle issue strobe. With it come the message fields and, for requests, the table hit and index. The granted source receives its dequeue or ready pulse in that same cycle.

A two-state machine controls the timing. In `ARB_IDLE` the block evaluates eligibility. If any source is eligible, it takes the transition "grant" to `ARB_ISSUE`; otherwise it stays in `ARB_IDLE`. `ARB_ISSUE` drives the strobe and always takes the transition "drain" back to `ARB_IDLE`. This leaves the popped source one cycle to present its next entry before the block decides again.

Top module: `dir_issue_arbiter`

## Requirements
- R1: While reset is held and in the first cycle after it, `iss_valid`, `iss_class`, `rpq_dequeue`, `rsp_ready` and `req_ready` are all low.
- R2: Among eligible sources, eviction wins over response and response wins over request. `iss_class` encodes the winner: 1 for eviction, 2 for response, 3 for request, and 0 when there is no issue.
- R3: The eviction head is eligible only when all of these hold: `rpq_valid` is high, `tt_full` is low, `rpl_lk_hit` is low, `dc2_busy` and `dc3_busy` are low, and `fwd_net_avail` and `rsp_net_avail` are high.
- R4: A response is eligible whenever `rsp_valid` is high, whatever the table, the networks and the downstream stages show.
- R5: A request needs all of these: `req_valid` high, `tt_full` low, both busy flags low and both networks available.
- R6: In addition to R5, a request must satisfy one of three cases: `req_lk_hit` is low; or it hits and `req_lk_entry_valid` is low; or it hits a valid entry that the stall decode does not stall.
- R7: The stall decode asserts only when three things hold together. First, the tracked state is transient: 4 (shared, awaiting data), 5 (modified, evicting), 6 (shared, evicting) or 7 (absent, awaiting memory data). Second, `req_src` equals `req_lk_owner`. Third, the type is 0 (read-shared), 1 (read-modify) or 2 (eviction). Type 3 (shared release) is never stalled, and neither is any requester other than the owner.
- R8: A decision made in `ARB_IDLE` appears one cycle later as `iss_valid` high. Exactly one of `rpq_dequeue`, `rsp_ready` and `req_ready` is high with it, and it belongs to the granted source.
- R9: The cycle after an issue never issues, even when sources stay eligible.
- R10: When no source is eligible, the strobe and all three pulses stay low.
- R11: The lookup outputs are combinational. The set field is the low `SET_W` address bits and the tag field is the remaining upper bits.
- R12: The issued fields are as follows. An eviction carries `rpq_addr`, type 2, source 0 and no hit. A response carries its own address, type and source, with no hit. A request carries its address, type and source, together with `req_lk_hit` and `req_lk_index`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rpq_valid | input | 1 | Eviction queue non-empty |
| rpq_addr | input | ADDR_W | Eviction head address |
| rpq_dequeue | output | 1 | Eviction queue pop pulse |
| rsp_valid | input | 1 | Response present |
| rsp_addr | input | ADDR_W | Response address |
| rsp_type | input | 2 | Response type |
| rsp_src | input | TILE_W | Response sender |
| rsp_ready | output | 1 | Response consumed pulse |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request address |
| req_type | input | 2 | Request type |
| req_src | input | TILE_W | Requester |
| req_ready | output | 1 | Request consumed pulse |
| rpl_lk_tag | output | TAG_W | Eviction lookup tag |
| rpl_lk_set | output | SET_W | Eviction lookup set |
| rpl_lk_hit | input | 1 | Eviction address tracked |
| req_lk_tag | output | TAG_W | Request lookup tag |
| req_lk_set | output | SET_W | Request lookup set |
| req_lk_hit | input | 1 | Request address tracked |
| req_lk_entry_valid | input | 1 | Tracked entry valid |
| req_lk_state | input | 3 | Tracked state |
| req_lk_owner | input | TILE_W | Tracked owner |
| req_lk_index | input | IDX_W | Tracked entry index |
| tt_full | input | 1 | Tracking table full |
| dc2_busy | input | 1 | Stage 2 busy |
| dc3_busy | input | 1 | Stage 3 busy |
| fwd_net_avail | input | 1 | Forward network available |
| rsp_net_avail | input | 1 | Response network available |
| iss_valid | output | 1 | Issue strobe to stage 2 |
| iss_class | output | 2 | Issued source class |
| iss_addr | output | ADDR_W | Issued address |
| iss_type | output | 2 | Issued message type |
| iss_src | output | TILE_W | Issued sender |
| iss_tt_hit | output | 1 | Issued table hit |
| iss_tt_index | output | IDX_W | Issued table index |

## Verification
Lookup tag and set are combinational, so the bench reads them in the same cycle it drives the address. The decision is taken on the clock edge that follows the drive. The strobe, class, fields and pulses are therefore checked just after that edge, one register later. One edge after that, the block has drained to idle, and the bench checks that nothing is issued while the sources are withdrawn. A held-eligible run checks the 1,0,1,0 strobe rhythm over four successive edges. All sampling falls 1 ns after a rising edge, with inputs changed on falling edges.

// File: rtl/dir_issue_pkg.sv
`timescale 1ns/1ps
package dir_issue_pkg;
    typedef enum logic [1:0] {
        MT_GETS  = 2'd0,
        MT_GETM  = 2'd1,
        MT_EVICT = 2'd2,
        MT_PUTS  = 2'd3
    } msg_type_e;

    typedef enum logic [2:0] {
        DS_N   = 3'd0,
        DS_I   = 3'd1,
        DS_S   = 3'd2,
        DS_M   = 3'd3,
        DS_SD  = 3'd4,
        DS_MNA = 3'd5,
        DS_SNA = 3'd6,
        DS_NSD = 3'd7
    } dir_state_e;

    typedef enum logic [1:0] {
        CL_NONE = 2'd0,
        CL_REPL = 2'd1,
        CL_RESP = 2'd2,
        CL_REQ  = 2'd3
    } src_class_e;

    typedef enum logic {
        ARB_IDLE  = 1'b0,
        ARB_ISSUE = 1'b1
    } arb_state_e;

    localparam int NUM_SRC = 3;
endpackage

// File: rtl/dir_issue_stall_decode.sv
`timescale 1ns/1ps
module dir_issue_stall_decode
    import dir_issue_pkg::*;
(
    input  logic [2:0] state_i,
    input  logic [1:0] type_i,
    input  logic       from_owner_i,
    output logic       stall_o
);
    dir_state_e st;
    msg_type_e  mt;
    logic       transient;
    logic       stallable;

    always_comb begin
        st = dir_state_e'(state_i);
        mt = msg_type_e'(type_i);
        unique case (st)
            DS_SD, DS_MNA, DS_SNA, DS_NSD: transient = 1'b1;
            default:                       transient = 1'b0;
        endcase
        unique case (mt)
            MT_GETS, MT_GETM, MT_EVICT: stallable = 1'b1;
            default:                    stallable = 1'b0;
        endcase
        stall_o = transient && stallable && from_owner_i;
    end
endmodule

// File: rtl/dir_issue_elig.sv
`timescale 1ns/1ps
module dir_issue_elig
    import dir_issue_pkg::*;
(
    input  logic               rpq_valid,
    input  logic               rpl_lk_hit,
    input  logic               rsp_valid,
    input  logic               req_valid,
    input  logic               req_lk_hit,
    input  logic               req_lk_entry_valid,
    input  logic               req_stall,
    input  logic               tt_full,
    input  logic               dc2_busy,
    input  logic               dc3_busy,
    input  logic               fwd_net_avail,
    input  logic               rsp_net_avail,
    output logic [NUM_SRC-1:0] elig_o
);
    logic path_clear;
    logic req_table_ok;

    always_comb begin
        path_clear   = !tt_full && !dc2_busy && !dc3_busy && fwd_net_avail && rsp_net_avail;
        req_table_ok = !req_lk_hit || !req_lk_entry_valid || !req_stall;
        elig_o[0]    = rpq_valid && path_clear && !rpl_lk_hit;
        elig_o[1]    = rsp_valid;
        elig_o[2]    = req_valid && path_clear && req_table_ok;
    end
endmodule

// File: rtl/dir_issue_prio_pick.sv
`timescale 1ns/1ps
module dir_issue_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    for (genvar g = 0; g < N; g++) begin : g_pick
        if (g == 0) begin : g_top
            assign gnt_o[g] = req_i[g];
        end else begin : g_rest
            assign gnt_o[g] = req_i[g] && !(|req_i[g-1:0]);
        end
    end
endmodule

// File: rtl/dir_issue_arbiter.sv
`timescale 1ns/1ps
module dir_issue_arbiter
    import dir_issue_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int SET_W  = 4,
    parameter int TILE_W = 3,
    parameter int IDX_W  = 2,
    localparam int ADDR_W = TAG_W + SET_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rpq_valid,
    input  logic [ADDR_W-1:0] rpq_addr,
    output logic              rpq_dequeue,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [1:0]        rsp_type,
    input  logic [TILE_W-1:0] rsp_src,
    output logic              rsp_ready,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_type,
    input  logic [TILE_W-1:0] req_src,
    output logic              req_ready,
    output logic [TAG_W-1:0]  rpl_lk_tag,
    output logic [SET_W-1:0]  rpl_lk_set,
    input  logic              rpl_lk_hit,
    output logic [TAG_W-1:0]  req_lk_tag,
    output logic [SET_W-1:0]  req_lk_set,
    input  logic              req_lk_hit,
    input  logic              req_lk_entry_valid,
    input  logic [2:0]        req_lk_state,
    input  logic [TILE_W-1:0] req_lk_owner,
    input  logic [IDX_W-1:0]  req_lk_index,
    input  logic              tt_full,
    input  logic              dc2_busy,
    input  logic              dc3_busy,
    input  logic              fwd_net_avail,
    input  logic              rsp_net_avail,
    output logic              iss_valid,
    output logic [1:0]        iss_class,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [1:0]        iss_type,
    output logic [TILE_W-1:0] iss_src,
    output logic              iss_tt_hit,
    output logic [IDX_W-1:0]  iss_tt_index
);
    arb_state_e         state_q, state_d;
    logic               req_stall;
    logic [NUM_SRC-1:0] elig, gnt;
    src_class_e         pick_class;
    logic [ADDR_W-1:0]  pick_addr;
    logic [1:0]         pick_type;
    logic [TILE_W-1:0]  pick_src;
    logic               pick_hit;
    logic [IDX_W-1:0]   pick_idx;
    logic               decide;

    assign rpl_lk_tag = rpq_addr[ADDR_W-1:SET_W];
    assign rpl_lk_set = rpq_addr[SET_W-1:0];
    assign req_lk_tag = req_addr[ADDR_W-1:SET_W];
    assign req_lk_set = req_addr[SET_W-1:0];

    dir_issue_stall_decode u_stall (
        .state_i      (req_lk_state),
        .type_i       (req_type),
        .from_owner_i (req_src == req_lk_owner),
        .stall_o      (req_stall)
    );

    dir_issue_elig u_elig (
        .rpq_valid          (rpq_valid),
        .rpl_lk_hit         (rpl_lk_hit),
        .rsp_valid          (rsp_valid),
        .req_valid          (req_valid),
        .req_lk_hit         (req_lk_hit),
        .req_lk_entry_valid (req_lk_entry_valid),
        .req_stall          (req_stall),
        .tt_full            (tt_full),
        .dc2_busy           (dc2_busy),
        .dc3_busy           (dc3_busy),
        .fwd_net_avail      (fwd_net_avail),
        .rsp_net_avail      (rsp_net_avail),
        .elig_o             (elig)
    );

    dir_issue_prio_pick #(.N(NUM_SRC)) u_pick (
        .req_i (elig),
        .gnt_o (gnt)
    );

    always_comb begin
        pick_class = CL_NONE;
        pick_addr  = '0;
        pick_type  = '0;
        pick_src   = '0;
        pick_hit   = 1'b0;
        pick_idx   = '0;
        unique case (gnt)
            3'b001: begin
                pick_class = CL_REPL;
                pick_addr  = rpq_addr;
                pick_type  = MT_EVICT;
            end
            3'b010: begin
                pick_class = CL_RESP;
                pick_addr  = rsp_addr;
                pick_type  = rsp_type;
                pick_src   = rsp_src;
            end
            3'b100: begin
                pick_class = CL_REQ;
                pick_addr  = req_addr;
                pick_type  = req_type;
                pick_src   = req_src;
                pick_hit   = req_lk_hit;
                pick_idx   = req_lk_index;
            end
            default: ;
        endcase
    end

    assign decide = (state_q == ARB_IDLE) && (|gnt);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (|elig) state_d = ARB_ISSUE;
            ARB_ISSUE: state_d = ARB_IDLE;
            default:   state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !decide) begin
            iss_valid    <= 1'b0;
            iss_class    <= CL_NONE;
            iss_addr     <= '0;
            iss_type     <= '0;
            iss_src      <= '0;
            iss_tt_hit   <= 1'b0;
            iss_tt_index <= '0;
            rpq_dequeue  <= 1'b0;
            rsp_ready    <= 1'b0;
            req_ready    <= 1'b0;
        end else begin
            iss_valid    <= 1'b1;
            iss_class    <= pick_class;
            iss_addr     <= pick_addr;
            iss_type     <= pick_type;
            iss_src      <= pick_src;
            iss_tt_hit   <= pick_hit;
            iss_tt_index <= pick_idx;
            rpq_dequeue  <= gnt[0];
            rsp_ready    <= gnt[1];
            req_ready    <= gnt[2];
        end
    end
endmodule

// File: rtl/dir_issue_arbiter_chk.sv
`timescale 1ns/1ps
module dir_issue_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rpq_valid,
    input logic       rpl_lk_hit,
    input logic       rsp_valid,
    input logic       req_valid,
    input logic       tt_full,
    input logic       dc2_busy,
    input logic       dc3_busy,
    input logic       fwd_net_avail,
    input logic       rsp_net_avail,
    input logic       iss_valid,
    input logic [1:0] iss_class,
    input logic       rpq_dequeue,
    input logic       rsp_ready,
    input logic       req_ready
);
    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rpq_dequeue, rsp_ready, req_ready}) <= 1); // R8
    AST_PULSE_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rpq_dequeue || rsp_ready || req_ready) |-> iss_valid); // R8
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |=> !iss_valid); // R9
    AST_RESP_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!iss_valid && rsp_valid) |=> iss_valid); // R4
    AST_EVICT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 2'd1) |-> $past(rpq_valid && !tt_full && !rpl_lk_hit &&
        !dc2_busy && !dc3_busy && fwd_net_avail && rsp_net_avail)); // R3
    AST_REQ_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 2'd3) |-> $past(req_valid && !tt_full &&
        !dc2_busy && !dc3_busy && fwd_net_avail && rsp_net_avail)); // R5
    AST_REQ_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_class == 2'd3) |-> $past(!rsp_valid && !rpq_valid || !rsp_valid && rpl_lk_hit
        || !rsp_valid && !rpq_valid)); // R2
endmodule

bind dir_issue_arbiter dir_issue_arbiter_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rpq_valid     (rpq_valid),
    .rpl_lk_hit    (rpl_lk_hit),
    .rsp_valid     (rsp_valid),
    .req_valid     (req_valid),
    .tt_full       (tt_full),
    .dc2_busy      (dc2_busy),
    .dc3_busy      (dc3_busy),
    .fwd_net_avail (fwd_net_avail),
    .rsp_net_avail (rsp_net_avail),
    .iss_valid     (iss_valid),
    .iss_class     (iss_class),
    .rpq_dequeue   (rpq_dequeue),
    .rsp_ready     (rsp_ready),
    .req_ready     (req_ready)
);

// File: tb/dir_issue_arbiter_bench.sv
`timescale 1ns/1ps
module dir_issue_arbiter_bench;
    localparam int TAG_W  = 6;
    localparam int SET_W  = 4;
    localparam int TILE_W = 3;
    localparam int IDX_W  = 2;
    localparam int ADDR_W = TAG_W + SET_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              rpq_valid, rpq_dequeue;
    logic [ADDR_W-1:0] rpq_addr;
    logic              rsp_valid, rsp_ready;
    logic [ADDR_W-1:0] rsp_addr;
    logic [1:0]        rsp_type;
    logic [TILE_W-1:0] rsp_src;
    logic              req_valid, req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        req_type;
    logic [TILE_W-1:0] req_src;
    logic [TAG_W-1:0]  rpl_lk_tag, req_lk_tag;
    logic [SET_W-1:0]  rpl_lk_set, req_lk_set;
    logic              rpl_lk_hit, req_lk_hit, req_lk_entry_valid;
    logic [2:0]        req_lk_state;
    logic [TILE_W-1:0] req_lk_owner;
    logic [IDX_W-1:0]  req_lk_index;
    logic              tt_full, dc2_busy, dc3_busy, fwd_net_avail, rsp_net_avail;
    logic              iss_valid, iss_tt_hit;
    logic [1:0]        iss_class, iss_type;
    logic [ADDR_W-1:0] iss_addr;
    logic [TILE_W-1:0] iss_src;
    logic [IDX_W-1:0]  iss_tt_index;

    dir_issue_arbiter #(.TAG_W(TAG_W), .SET_W(SET_W), .TILE_W(TILE_W), .IDX_W(IDX_W)) u_dir_issue_arbiter (
        .clk(clk), .rst_n(rst_n),
        .rpq_valid(rpq_valid), .rpq_addr(rpq_addr), .rpq_dequeue(rpq_dequeue),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_type(rsp_type), .rsp_src(rsp_src), .rsp_ready(rsp_ready),
        .req_valid(req_valid), .req_addr(req_addr), .req_type(req_type), .req_src(req_src), .req_ready(req_ready),
        .rpl_lk_tag(rpl_lk_tag), .rpl_lk_set(rpl_lk_set), .rpl_lk_hit(rpl_lk_hit),
        .req_lk_tag(req_lk_tag), .req_lk_set(req_lk_set), .req_lk_hit(req_lk_hit),
        .req_lk_entry_valid(req_lk_entry_valid), .req_lk_state(req_lk_state),
        .req_lk_owner(req_lk_owner), .req_lk_index(req_lk_index),
        .tt_full(tt_full), .dc2_busy(dc2_busy), .dc3_busy(dc3_busy),
        .fwd_net_avail(fwd_net_avail), .rsp_net_avail(rsp_net_avail),
        .iss_valid(iss_valid), .iss_class(iss_class), .iss_addr(iss_addr), .iss_type(iss_type),
        .iss_src(iss_src), .iss_tt_hit(iss_tt_hit), .iss_tt_index(iss_tt_index)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic clear_inputs();
        rpq_valid = 0; rsp_valid = 0; req_valid = 0;
        rpq_addr = '0; rsp_addr = '0; req_addr = '0;
        rsp_type = '0; rsp_src = '0; req_type = '0; req_src = '0;
        rpl_lk_hit = 0; req_lk_hit = 0; req_lk_entry_valid = 0;
        req_lk_state = '0; req_lk_owner = '0; req_lk_index = '0;
        tt_full = 0; dc2_busy = 0; dc3_busy = 0; fwd_net_avail = 1; rsp_net_avail = 1;
    endtask

    // flag bits: 0 rpq_v,1 full,2 rpl_hit,3 busy2,4 busy3,5 fwd,6 rspnet,7 rsp_v,8 req_v,9 req_hit,10 req_ev,11 owner
    task automatic run_vec(input logic [11:0] f, input logic [2:0] st, input logic [1:0] ty, input int seed);
        logic path, e_repl, e_resp, e_req, stall;
        logic [1:0] ecls;
        logic [ADDR_W-1:0] eaddr;
        logic [1:0] etype;
        logic [TILE_W-1:0] esrc;
        logic ehit;
        logic [IDX_W-1:0] eidx;
        @(negedge clk);
        rpq_valid = f[0]; tt_full = f[1]; rpl_lk_hit = f[2]; dc2_busy = f[3]; dc3_busy = f[4];
        fwd_net_avail = f[5]; rsp_net_avail = f[6]; rsp_valid = f[7]; req_valid = f[8];
        req_lk_hit = f[9]; req_lk_entry_valid = f[10];
        req_lk_state = st; req_type = ty;
        rpq_addr = ADDR_W'(seed * 7 + 3);
        rsp_addr = ADDR_W'(seed * 13 + 5);
        req_addr = ADDR_W'(seed * 29 + 11);
        rsp_type = 2'(seed);
        rsp_src = TILE_W'(seed + 1);
        req_lk_owner = TILE_W'(seed * 3);
        req_src = f[11] ? req_lk_owner : (req_lk_owner ^ TILE_W'(1));
        req_lk_index = IDX_W'(seed);
        #1;
        chk(req_lk_set == req_addr[SET_W-1:0] && req_lk_tag == req_addr[ADDR_W-1:SET_W], "R11 req lookup",
            {req_lk_tag, req_lk_set}, req_addr);
        chk(rpl_lk_set == rpq_addr[SET_W-1:0] && rpl_lk_tag == rpq_addr[ADDR_W-1:SET_W], "R11 evict lookup",
            {rpl_lk_tag, rpl_lk_set}, rpq_addr);
        stall  = (st >= 3'd4) && f[11] && (ty != 2'd3);                        // R7
        path   = !f[1] && !f[3] && !f[4] && f[5] && f[6];
        e_repl = f[0] && path && !f[2];                                        // R3
        e_resp = f[7];                                                          // R4
        e_req  = f[8] && path && (!f[9] || !f[10] || !stall);                   // R5 R6
        ecls   = e_repl ? 2'd1 : e_resp ? 2'd2 : e_req ? 2'd3 : 2'd0;           // R2
        eaddr = '0; etype = '0; esrc = '0; ehit = 0; eidx = '0;
        if (ecls == 2'd1) begin eaddr = rpq_addr; etype = 2'd2; end
        if (ecls == 2'd2) begin eaddr = rsp_addr; etype = rsp_type; esrc = rsp_src; end
        if (ecls == 2'd3) begin eaddr = req_addr; etype = ty; esrc = req_src; ehit = f[9]; eidx = req_lk_index; end
        @(posedge clk); #1;
        chk(iss_valid == (ecls != 0), "R8 R10 strobe", iss_valid, ecls != 0);
        chk(iss_class == ecls, "R2 R3 R4 R5 R6 R7 class", iss_class, ecls);
        chk({rpq_dequeue, rsp_ready, req_ready} == {ecls == 2'd1, ecls == 2'd2, ecls == 2'd3},
            "R8 pulses", {rpq_dequeue, rsp_ready, req_ready}, {ecls == 2'd1, ecls == 2'd2, ecls == 2'd3});
        if (ecls != 0)
            chk({iss_addr, iss_type, iss_src, iss_tt_hit, iss_tt_index} == {eaddr, etype, esrc, ehit, eidx},
                "R12 fields", {iss_addr, iss_type, iss_src, iss_tt_hit, iss_tt_index},
                {eaddr, etype, esrc, ehit, eidx});
        @(negedge clk);
        rpq_valid = 0; rsp_valid = 0; req_valid = 0;
        @(posedge clk); #1;
        chk(!iss_valid && !rpq_dequeue && !rsp_ready && !req_ready, "R9 R10 drained",
            {iss_valid, rpq_dequeue, rsp_ready, req_ready}, 0);
    endtask

    initial begin
        clear_inputs();
        repeat (3) @(posedge clk);
        #1;
        chk(!iss_valid && iss_class == 0 && !rpq_dequeue && !rsp_ready && !req_ready, "R1 in reset",
            {iss_valid, iss_class, rpq_dequeue, rsp_ready, req_ready}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk(!iss_valid && !rpq_dequeue && !rsp_ready && !req_ready, "R1 after reset",
            {iss_valid, rpq_dequeue, rsp_ready, req_ready}, 0);

        // near-exhaustive sweep of all condition flags
        for (int i = 0; i < 4096; i++)
            run_vec(12'(i), 3'((i * 5 + (i >> 3)) % 8), 2'((i * 3 + (i >> 5)) % 4), i);

        // exhaustive stall decode: state x type x ownership, request only, hit valid entry
        for (int s = 0; s < 8; s++)
            for (int t = 0; t < 4; t++)
                for (int o = 0; o < 2; o++)
                    run_vec({1'(o), 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
                            3'(s), 2'(t), s * 8 + t * 2 + o);

        // R9: sources held eligible give a strobe every other cycle
        @(negedge clk);
        clear_inputs();
        rpq_valid = 1; rsp_valid = 1; req_valid = 1;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk); #1;
            chk(iss_valid == ((k % 2) == 0), "R9 rhythm", iss_valid, (k % 2) == 0);
            chk(iss_class == (((k % 2) == 0) ? 2'd1 : 2'd0), "R2 R9 held class", iss_class,
                ((k % 2) == 0) ? 2'd1 : 2'd0);
        end
        @(negedge clk);
        clear_inputs();
        repeat (2) @(posedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule